// File: doc/BRIEF.md
# Video Timing Reference Code Decoder

This block monitors a video byte stream that carries its synchronisation embedded in the data. It searches for the marker that introduces a timing reference code: one all-ones word followed by all-zeros words, each arriving on a valid cycle. The status word that comes right after the marker is decoded. From it the block extracts three flags: the field identifier, vertical blanking, and whether the code closes (end of active video) or opens (start of active video) the active part of a line.

The status word carries four parity bits over the three flags. Together they form a seven-bit code with a minimum distance of four. The decoder repairs any single flipped bit and recognises two flipped bits. For a two-bit error there is a defined fallback. The field and blanking flags are taken as received. The active-video flag is set to the inverse of the value it held after the previous code, which keeps the start/end alternation going across a damaged code. Each decoded code produces a one-clock strobe, together with correction and double-error status. The three flags keep their values until the next code.

The marker length, the data width and the style of the error-pattern lookup are parameters. Downstream line and field timing logic uses the decoder's outputs.

Top module: `trc_decoder`

## Requirements
- R1: After a synchronous reset, trc_valid, err_corrected, err_double, field_o and vblank_o are 0 and eav_o is 1.
- R2: A word is taken as a status word only when it is valid and directly follows the words 0xFF, 0x00, 0x00 on consecutive valid cycles. trc_valid is then high for exactly one clock, in the cycle after the clock edge that samples the status word.
- R3: Cycles with din_valid low are ignored. They neither advance nor break the marker search, and they never produce a status.
- R4: A valid word that does not fit the marker restarts the search. If that word is 0xFF it counts as the first marker word, so 0xFF 0xFF 0x00 0x00 is a complete marker.
- R5: Status word bits: bit 6 = field, bit 5 = vblank, bit 4 = eav, bits 3..0 = parity p3..p0. An error-free word has p3 = vblank^eav, p2 = field^eav, p1 = field^vblank and p0 = field^vblank^eav. Such a word is reported as received, with err_corrected = 0 and err_double = 0.
- R6: A status word that differs from a valid codeword in exactly one of bits 6..0 is reported as that codeword's flags, with err_corrected = 1.
- R7: Any other status word sets err_double = 1. field_o and vblank_o then equal received bits 6 and 5, and eav_o is the inverse of eav_o before the strobe.
- R8: err_corrected and err_double are 0 when trc_valid is 0, and they are never both 1. field_o, vblank_o and eav_o change only on a strobe.
- R9: Bit 7 of the status word has no effect on any output.
- R10: The first double-error fallback after reset yields eav_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_valid | input | 1 | Qualifies din |
| din | input | DATA_W | Video stream word |
| trc_valid | output | 1 | One-clock strobe per decoded code |
| field_o | output | 1 | Field flag of the last code |
| vblank_o | output | 1 | Vertical blanking flag of the last code |
| eav_o | output | 1 | 1 = end of active video, 0 = start |
| err_corrected | output | 1 | Single-bit error repaired (with strobe) |
| err_double | output | 1 | Uncorrectable error, fallback used (with strobe) |

## Verification
The assertions assume that din_valid and din hold known values on every sampled edge and that reset is synchronous. They also rely on a status word never directly following another, because every code needs its full marker first. The stimulus drives all inputs on the falling edge and keeps din_valid defined throughout, including idle gaps inside markers. Random codes carry zero, one or two injected bit errors plus a random bit 7. These are mixed with random filler words, and the filler can form partial or accidental markers.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam int unsigned STAT_W = 7;
   localparam int unsigned SYND_W = 4;

   typedef struct packed {
      logic fld;
      logic vbl;
      logic eav;
   } trc_flags_t;

   // word: [6]=field [5]=vblank [4]=eav [3:0]=parity p3..p0
   function automatic logic [SYND_W-1:0] trc_syndrome(input logic [STAT_W-1:0] w);
      logic [SYND_W-1:0] s;
      s[3] = w[3] ^ w[5] ^ w[4];
      s[2] = w[2] ^ w[6] ^ w[4];
      s[1] = w[1] ^ w[6] ^ w[5];
      s[0] = w[0] ^ w[6] ^ w[5] ^ w[4];
      return s;
   endfunction

   function automatic logic [SYND_W-1:0] trc_column(input int unsigned idx);
      logic [STAT_W-1:0] u;
      u = '0;
      u[idx[2:0]] = 1'b1;
      return trc_syndrome(u);
   endfunction

endpackage

// File: rtl/trc_preamble_detect.sv
module trc_preamble_detect #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PRE_LEN = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       din_valid,
   input  logic [DATA_W-1:0]          din,
   output logic                       hit_o,
   output logic [trc_pkg::STAT_W-1:0] word_o
);
   localparam int unsigned CW = $clog2(PRE_LEN + 1);

   logic [CW-1:0]      cnt_q, cnt_d;
   logic [PRE_LEN-1:0] match;
   logic               sel_match;

   generate
      for (genvar g = 0; g < PRE_LEN; g++) begin : g_cmp
         if (g == 0) begin : g_ones
            assign match[g] = (din == {DATA_W{1'b1}});
         end else begin : g_zero
            assign match[g] = (din == {DATA_W{1'b0}});
         end
      end
   endgenerate

   always_comb begin
      sel_match = 1'b0;
      for (int unsigned i = 0; i < PRE_LEN; i++) begin
         if (cnt_q == CW'(i)) sel_match = match[i];
      end
   end

   always_comb begin
      cnt_d = cnt_q;
      hit_o = 1'b0;
      if (din_valid) begin
         if (cnt_q == CW'(PRE_LEN)) begin
            hit_o = 1'b1;
            cnt_d = '0;
         end else if (sel_match) begin
            cnt_d = cnt_q + CW'(1);
         end else if (match[0]) begin
            cnt_d = CW'(1);
         end else begin
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   assign word_o = din[DATA_W-2 -: trc_pkg::STAT_W];

endmodule

// File: rtl/trc_hamming_correct.sv
module trc_hamming_correct
   import trc_pkg::*;
#(
   parameter bit USE_LUT = 1'b1
) (
   input  logic [STAT_W-1:0] word_i,
   input  logic              prev_eav_i,
   output trc_flags_t        flags_o,
   output logic              corr_o,
   output logic              dbl_o
);
   logic [SYND_W-1:0] synd;
   logic [STAT_W-1:0] flip;
   logic [STAT_W-1:0] fixed;
   logic              single;

   assign synd = trc_syndrome(word_i);

   generate
      if (USE_LUT) begin : g_lut
         always_comb begin
            case (synd)
               4'b0111: flip = 7'b100_0000;
               4'b1011: flip = 7'b010_0000;
               4'b1101: flip = 7'b001_0000;
               4'b1000: flip = 7'b000_1000;
               4'b0100: flip = 7'b000_0100;
               4'b0010: flip = 7'b000_0010;
               4'b0001: flip = 7'b000_0001;
               default: flip = 7'b000_0000;
            endcase
         end
      end else begin : g_scan
         always_comb begin
            flip = '0;
            for (int unsigned i = 0; i < STAT_W; i++) begin
               if (synd == trc_column(i)) flip[i] = 1'b1;
            end
         end
      end
   endgenerate

   assign single = |flip;
   assign fixed  = word_i ^ flip;

   always_comb begin
      corr_o  = 1'b0;
      dbl_o   = 1'b0;
      flags_o = '{fld: word_i[6], vbl: word_i[5], eav: word_i[4]};
      if (synd != '0) begin
         if (single) begin
            corr_o  = 1'b1;
            flags_o = '{fld: fixed[6], vbl: fixed[5], eav: fixed[4]};
         end else begin
            dbl_o   = 1'b1;
            flags_o = '{fld: word_i[6], vbl: word_i[5], eav: ~prev_eav_i};
         end
      end
   end

endmodule

// File: rtl/trc_out_reg.sv
module trc_out_reg
   import trc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load_i,
   input  trc_flags_t flags_i,
   input  logic       corr_i,
   input  logic       dbl_i,
   output logic       strobe_o,
   output trc_flags_t flags_o,
   output logic       corr_o,
   output logic       dbl_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         strobe_o <= 1'b0;
         corr_o   <= 1'b0;
         dbl_o    <= 1'b0;
         flags_o  <= '{fld: 1'b0, vbl: 1'b0, eav: 1'b1};
      end else begin
         strobe_o <= load_i;
         corr_o   <= load_i & corr_i;
         dbl_o    <= load_i & dbl_i;
         if (load_i) flags_o <= flags_i;
      end
   end
endmodule

// File: rtl/trc_decoder.sv
module trc_decoder
   import trc_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PRE_LEN = 3,
   parameter bit          USE_LUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din_valid,
   input  logic [DATA_W-1:0] din,
   output logic              trc_valid,
   output logic              field_o,
   output logic              vblank_o,
   output logic              eav_o,
   output logic              err_corrected,
   output logic              err_double
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("trc_decoder: DATA_W must be at least 8");
      end
      if (PRE_LEN < 2) begin : g_bad_len
         $error("trc_decoder: PRE_LEN must be at least 2");
      end
   endgenerate

   logic              hit;
   logic [STAT_W-1:0] word;
   trc_flags_t        dec_flags, reg_flags;
   logic              dec_corr, dec_dbl;

   trc_preamble_detect #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_pre (
      .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
      .hit_o(hit), .word_o(word)
   );

   trc_hamming_correct #(.USE_LUT(USE_LUT)) u_ham (
      .word_i(word), .prev_eav_i(reg_flags.eav),
      .flags_o(dec_flags), .corr_o(dec_corr), .dbl_o(dec_dbl)
   );

   trc_out_reg u_out (
      .clk(clk), .rst(rst), .load_i(hit), .flags_i(dec_flags),
      .corr_i(dec_corr), .dbl_i(dec_dbl), .strobe_o(trc_valid),
      .flags_o(reg_flags), .corr_o(err_corrected), .dbl_o(err_double)
   );

   assign field_o  = reg_flags.fld;
   assign vblank_o = reg_flags.vbl;
   assign eav_o    = reg_flags.eav;

endmodule

// File: rtl/trc_decoder_chk.sv
module trc_decoder_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              din_valid,
   input logic [DATA_W-1:0] din,
   input logic              trc_valid,
   input logic              field_o,
   input logic              vblank_o,
   input logic              eav_o,
   input logic              err_corrected,
   input logic              err_double
);
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      trc_valid |=> !trc_valid);

   p_strobe_cause_r3: assert property (@(posedge clk) disable iff (rst)
      trc_valid |-> $past(din_valid));

   p_err_qual_r8: assert property (@(posedge clk) disable iff (rst)
      !trc_valid |-> !(err_corrected || err_double));

   p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
      trc_valid |-> !(err_corrected && err_double));

   p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !trc_valid |-> $stable({field_o, vblank_o, eav_o}));

   p_fallback_eav_r7: assert property (@(posedge clk) disable iff (rst)
      (trc_valid && err_double) |-> (eav_o != $past(eav_o)));

   p_fallback_raw_r7: assert property (@(posedge clk) disable iff (rst)
      (trc_valid && err_double) |->
         (field_o == $past(din[DATA_W-2]) && vblank_o == $past(din[DATA_W-3])));

endmodule

bind trc_decoder trc_decoder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
   .trc_valid(trc_valid), .field_o(field_o), .vblank_o(vblank_o),
   .eav_o(eav_o), .err_corrected(err_corrected), .err_double(err_double)
);

// File: tb/tb_trc_decoder.sv
`timescale 1ns/1ps
module tb_trc_decoder;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din_valid = 1'b0;
   logic [7:0] din = 8'h00;
   logic       trc_valid, field_o, vblank_o, eav_o, err_corrected, err_double;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int m_cnt = 0;
   logic m_f = 1'b0, m_v = 1'b0, m_h = 1'b1, m_c = 1'b0, m_d = 1'b0;

   always #10 clk = ~clk;

   trc_decoder dut (
      .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
      .trc_valid(trc_valid), .field_o(field_o), .vblank_o(vblank_o),
      .eav_o(eav_o), .err_corrected(err_corrected), .err_double(err_double)
   );

   function automatic logic [3:0] par_of(input logic [2:0] fvh);
      case (fvh)
         3'b000: par_of = 4'b0000;
         3'b001: par_of = 4'b1101;
         3'b010: par_of = 4'b1011;
         3'b011: par_of = 4'b0110;
         3'b100: par_of = 4'b0111;
         3'b101: par_of = 4'b1010;
         3'b110: par_of = 4'b1100;
         default: par_of = 4'b0001;
      endcase
   endfunction

   function automatic logic [7:0] code_of(input logic [2:0] fvh, input logic b7);
      return {b7, fvh, par_of(fvh)};
   endfunction

   // returns {f, v, h, corrected, double}
   function automatic logic [4:0] ref_decode(input logic [6:0] w, input logic prev_h);
      for (int c = 0; c < 8; c++) begin
         logic [6:0] cw;
         cw = {3'(c), par_of(3'(c))};
         if ((cw ^ w) == 7'd0) return {3'(c), 2'b00};
      end
      for (int c = 0; c < 8; c++) begin
         logic [6:0] cw;
         cw = {3'(c), par_of(3'(c))};
         if ($countones(cw ^ w) == 1) return {3'(c), 2'b10};
      end
      return {w[6], w[5], ~prev_h, 2'b01};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic v, input string tag);
      logic       hit;
      logic [4:0] d;
      @(negedge clk);
      din_valid = v;
      din       = b;
      hit       = 1'b0;
      if (v) begin
         if (m_cnt == 3) begin
            hit = 1'b1; m_cnt = 0;
         end else if ((m_cnt == 0 && b == 8'hFF) || (m_cnt != 0 && b == 8'h00)) begin
            m_cnt++;
         end else if (b == 8'hFF) begin
            m_cnt = 1;
         end else begin
            m_cnt = 0;
         end
      end
      if (hit) begin
         d = ref_decode(b[6:0], m_h);
         {m_f, m_v, m_h, m_c, m_d} = d;
      end
      @(posedge clk);
      #1;
      chk(trc_valid == hit, {tag, " strobe"}, 32'(trc_valid), 32'(hit));
      chk({field_o, vblank_o, eav_o} == {m_f, m_v, m_h}, {tag, " flags"},
          32'({field_o, vblank_o, eav_o}), 32'({m_f, m_v, m_h}));
      chk({err_corrected, err_double} == (hit ? {m_c, m_d} : 2'b00), {tag, " err"},
          32'({err_corrected, err_double}), 32'(hit ? {m_c, m_d} : 2'b00));
   endtask

   task automatic marker(input string tag);
      send(8'hFF, 1'b1, tag);
      send(8'h00, 1'b1, tag);
      send(8'h00, 1'b1, tag);
   endtask

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      #1;
      chk({trc_valid, err_corrected, err_double, field_o, vblank_o, eav_o} == 6'b000001,
          "R1 reset", 32'({trc_valid, err_corrected, err_double, field_o, vblank_o, eav_o}), 32'h1);
      @(negedge clk);
      rst = 1'b0;

      // R10: first fallback after reset, two flips on codeword 000
      marker("R10");
      send(8'b1000_0011, 1'b1, "R10");
      chk(eav_o == 1'b0 && err_double, "R10 first fallback", 32'({eav_o, err_double}), 32'b01);

      // R5: every clean codeword
      for (int c = 0; c < 8; c++) begin
         marker("R5");
         send(code_of(3'(c), 1'b1), 1'b1, "R5");
      end

      // R6: field bit flipped in codeword 101
      marker("R6");
      send(code_of(3'b101, 1'b1) ^ 8'h40, 1'b1, "R6");
      chk(err_corrected && {field_o, vblank_o, eav_o} == 3'b101, "R6 corrected",
          32'({err_corrected, field_o, vblank_o, eav_o}), 32'b1101);

      // R3: idle cycles inside the marker carry marker-breaking values
      send(8'hFF, 1'b1, "R3");
      send(8'h55, 1'b0, "R3");
      send(8'h00, 1'b1, "R3");
      send(8'hFF, 1'b0, "R3");
      send(8'h00, 1'b1, "R3");
      send(8'h12, 1'b0, "R3");
      send(code_of(3'b011, 1'b1), 1'b1, "R3");
      send(code_of(3'b110, 1'b1), 1'b0, "R3");

      // R4: broken marker, then repeated 0xFF, then 0xFF re-entering mid-marker
      send(8'hFF, 1'b1, "R4");
      send(8'h00, 1'b1, "R4");
      send(8'h55, 1'b1, "R4");
      send(8'h00, 1'b1, "R4");
      send(8'h00, 1'b1, "R4");
      send(code_of(3'b100, 1'b1), 1'b1, "R4");
      send(8'hFF, 1'b1, "R4");
      marker("R4");
      send(code_of(3'b010, 1'b1), 1'b1, "R4");
      send(8'hFF, 1'b1, "R4");
      send(8'h00, 1'b1, "R4");
      marker("R4");
      send(code_of(3'b111, 1'b1), 1'b1, "R4");

      // R9: bit 7 cleared
      marker("R9");
      send(code_of(3'b110, 1'b0), 1'b1, "R9");
      marker("R9");
      send(code_of(3'b001, 1'b0) ^ 8'h01, 1'b1, "R9");

      // R7: double error with known previous eav (currently 1)
      marker("R7");
      send(code_of(3'b011, 1'b1) ^ 8'h30, 1'b1, "R7");
      chk(err_double && eav_o == 1'b0, "R7 fallback", 32'({err_double, eav_o}), 32'b10);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 3) begin
            int         k;
            logic [7:0] st;
            string      tag;
            k  = int'($urandom % 3);
            st = code_of(3'($urandom % 8), 1'($urandom % 2));
            if (k >= 1) begin
               int i;
               int j;
               i = int'($urandom % 7);
               st[i] = ~st[i];
               if (k == 2) begin
                  j = (i + 1 + int'($urandom % 6)) % 7;
                  st[j] = ~st[j];
               end
            end
            tag = (k == 0) ? "R5" : ((k == 1) ? "R6" : "R7");
            send(8'hFF, 1'b1, "R2");
            if ($urandom % 4 == 0) send(8'($urandom), 1'b0, "R3");
            send(8'h00, 1'b1, "R2");
            send(8'h00, 1'b1, "R2");
            if ($urandom % 4 == 0) send(8'($urandom), 1'b0, "R3");
            send(st, 1'b1, tag);
         end else begin
            logic [7:0] b;
            b = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
            send(b, 1'($urandom % 3 != 0), "R2");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule